// File: doc/BRIEF.md
# Packed Signed Greater-Than Comparator

This unit compares two 256-bit source vectors lane by lane. Each lane is treated as a two's-complement integer. When the lane in source A is strictly larger than the lane in source B, the matching destination lane is filled with ones. In every other case it is filled with zeros. The lane width is chosen at run time from 8, 16, 32 or 64 bits.

A destination-mode input decides what happens to the upper 128 bits of the result:

- **Keep:** the previous destination contents, supplied on an input, are passed through unchanged.
- **Clear:** the upper bits are forced to zero.
- **Wide:** the upper bits hold compare results, which doubles the lane count.

Operands are captured when `in_valid` is high. The result appears one clock later, together with `out_valid`. When no operation is presented, the registered result holds its value.

Top module: `simd_sgt_cmp`

## Requirements
- R1: Each destination lane is all ones when the source A lane, read as a signed integer, is strictly greater than the source B lane. Otherwise the lane is all zeros. Equal lanes give zeros. A lane holding the most negative value never beats another lane.
- R2: `size_sel` picks the lane width: 2'b00 is 8 bits, 2'b01 is 16, 2'b10 is 32 and 2'b11 is 64. Lane 0 sits in the least significant bits and lane k occupies bits [k*w+w-1 : k*w].
- R3: With `mode_sel` = 2'b00 (keep), bits [127:0] hold compare results and bits [255:128] equal `dst_old[255:128]` as sampled with the operation.
- R4: With `mode_sel` = 2'b01 (clear), bits [127:0] hold compare results and bits [255:128] are zero.
- R5: With `mode_sel` = 2'b10 (wide), all 256 bits hold compare results, for example 32 byte lanes.
- R6: `mode_sel` = 2'b11 behaves exactly like 2'b10.
- R7: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low otherwise. A synchronous active-high `rst` clears `out_valid` and `dst_out`.
- R8: Within the selected lane width, every result lane is uniformly all ones or all zeros. No lane carries a mix.
- R9: While `in_valid` is low, `dst_out` keeps its last value, whatever happens on the operand inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands present this cycle |
| src_a | input | 256 | First source vector |
| src_b | input | 256 | Second source vector |
| dst_old | input | 256 | Prior destination contents, used in keep mode |
| size_sel | input | 2 | Lane width select |
| mode_sel | input | 2 | Upper-half handling select |
| out_valid | output | 1 | Result valid |
| dst_out | output | 256 | Registered result vector |

## Verification
The bench concentrates on the signed boundary. It pairs the most negative and most positive lane values in both orders, and also uses equal operands.

- A comparator that compared unsigned would report 0x80 as greater than 0x7F.
- A comparator that used greater-or-equal would set lanes for equal inputs.

Lane-order tests raise a single lane per width. A design with swapped or misaligned lanes would set the wrong bits or would mix partial masks across the boundary of a lane.

Each of the four mode codes is driven with a nonzero `dst_old`. This exposes an upper half that leaks stale data in clear mode, loses the old value in keep mode, or treats the reserved code as a 128-bit mode.

// File: rtl/sgt_pkg.sv
package sgt_pkg;

   typedef enum logic [1:0] {
      ELEM_8  = 2'b00,
      ELEM_16 = 2'b01,
      ELEM_32 = 2'b10,
      ELEM_64 = 2'b11
   } elem_e;

   typedef enum logic [1:0] {
      HI_KEEP  = 2'b00,
      HI_CLEAR = 2'b01,
      HI_WIDE  = 2'b10,
      HI_RSVD  = 2'b11
   } hi_mode_e;

   localparam int unsigned MIN_LANE_W = 8;
   localparam int unsigned MAX_LANE_W = 64;

endpackage

// File: rtl/sgt_chunk.sv
// One MAX_LANE_W-wide slice: every lane width computed in parallel, then selected.
module sgt_chunk
   import sgt_pkg::*;
#(
   parameter int unsigned CHUNK_W = MAX_LANE_W,
   parameter int unsigned LANE_MIN = MIN_LANE_W
) (
   input  logic [CHUNK_W-1:0] a,
   input  logic [CHUNK_W-1:0] b,
   input  logic [1:0]         size_sel,
   output logic [CHUNK_W-1:0] mask
);
   localparam int unsigned NSZ = $clog2(CHUNK_W / LANE_MIN) + 1;

   if (NSZ != 4) begin : g_bad_nsz
      $error("sgt_chunk: CHUNK_W/LANE_MIN must give exactly four lane widths");
   end
   if ((CHUNK_W % LANE_MIN) != 0) begin : g_bad_div
      $error("sgt_chunk: CHUNK_W must be a multiple of LANE_MIN");
   end

   logic [NSZ-1:0][CHUNK_W-1:0] per_size;

   for (genvar s = 0; s < NSZ; s++) begin : g_sz
      localparam int unsigned LW = LANE_MIN << s;
      localparam int unsigned NL = CHUNK_W / LW;
      for (genvar l = 0; l < NL; l++) begin : g_ln
         logic gt;
         assign gt = $signed(a[l*LW +: LW]) > $signed(b[l*LW +: LW]);
         assign per_size[s][l*LW +: LW] = {LW{gt}};
      end
   end

   assign mask = per_size[size_sel];

endmodule

// File: rtl/sgt_half_sel.sv
// Chooses the upper half of the destination from the mode select.
module sgt_half_sel
   import sgt_pkg::*;
#(
   parameter int unsigned VEC_W = 256
) (
   input  logic [VEC_W-1:0] computed,
   input  logic [VEC_W-1:0] dst_old,
   input  logic [1:0]       mode_sel,
   output logic [VEC_W-1:0] result
);
   localparam int unsigned HALF_W = VEC_W / 2;

   if ((VEC_W % 2) != 0) begin : g_bad_half
      $error("sgt_half_sel: VEC_W must be even");
   end

   hi_mode_e mode;
   assign mode = hi_mode_e'(mode_sel);

   logic [HALF_W-1:0] upper;

   always_comb begin
      unique case (mode)
         HI_KEEP:  upper = dst_old[VEC_W-1:HALF_W];
         HI_CLEAR: upper = '0;
         default:  upper = computed[VEC_W-1:HALF_W];
      endcase
   end

   assign result = {upper, computed[HALF_W-1:0]};

endmodule

// File: rtl/sgt_out_reg.sv
// Result register with valid flag; data loads only on an accepted operation.
module sgt_out_reg #(
   parameter int unsigned W = 256
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         valid
);
   always_ff @(posedge clk) begin
      if (rst) begin
         valid <= 1'b0;
         q     <= '0;
      end else begin
         valid <= load;
         if (load) q <= d;
      end
   end
endmodule

// File: rtl/simd_sgt_cmp.sv
module simd_sgt_cmp
   import sgt_pkg::*;
#(
   parameter int unsigned VEC_W = 256
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   input  logic [VEC_W-1:0] dst_old,
   input  logic [1:0]       size_sel,
   input  logic [1:0]       mode_sel,
   output logic             out_valid,
   output logic [VEC_W-1:0] dst_out
);
   localparam int unsigned CHUNK_W = MAX_LANE_W;
   localparam int unsigned NCHUNK  = VEC_W / CHUNK_W;
   localparam int unsigned HALF_W  = VEC_W / 2;

   if ((VEC_W % (2 * CHUNK_W)) != 0) begin : g_bad_vec
      $error("simd_sgt_cmp: VEC_W must be a multiple of twice the widest lane");
   end

   logic [VEC_W-1:0] computed;
   logic [VEC_W-1:0] merged;

   for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
      sgt_chunk #(.CHUNK_W(CHUNK_W), .LANE_MIN(MIN_LANE_W)) u_chunk (
         .a        (src_a[c*CHUNK_W +: CHUNK_W]),
         .b        (src_b[c*CHUNK_W +: CHUNK_W]),
         .size_sel (size_sel),
         .mask     (computed[c*CHUNK_W +: CHUNK_W])
      );
   end

   sgt_half_sel #(.VEC_W(VEC_W)) u_half (
      .computed (computed),
      .dst_old  (dst_old),
      .mode_sel (mode_sel),
      .result   (merged)
   );

   sgt_out_reg #(.W(VEC_W)) u_reg (
      .clk   (clk),
      .rst   (rst),
      .load  (in_valid),
      .d     (merged),
      .q     (dst_out),
      .valid (out_valid)
   );

   // R7: latency of exactly one cycle
   assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   assert_valid_idle_R7: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R3: keep mode passes the old upper half through
   assert_keep_upper_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode_sel == 2'b00) |=>
         dst_out[VEC_W-1:HALF_W] == $past(dst_old[VEC_W-1:HALF_W]));

   // R4: clear mode zeros the upper half
   assert_clear_upper_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode_sel == 2'b01) |=> dst_out[VEC_W-1:HALF_W] == '0);

   // R9: result holds when idle
   assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(dst_out));

   // R1: lowest 64-bit lane in 64-bit mode matches a signed compare of the inputs
   assert_q0_signed_R1: assert property (@(posedge clk) disable iff (rst)
      (in_valid && size_sel == 2'b11) |=>
         dst_out[63:0] == (($signed($past(src_a[63:0])) > $signed($past(src_b[63:0])))
                           ? {64{1'b1}} : 64'd0));

   // R8: top byte lane is uniform in wide byte mode
   assert_top_byte_uniform_R8: assert property (@(posedge clk) disable iff (rst)
      (in_valid && size_sel == 2'b00 && mode_sel[1]) |=>
         (dst_out[VEC_W-1 -: 8] == 8'h00 || dst_out[VEC_W-1 -: 8] == 8'hFF));

endmodule

// File: tb/simd_sgt_cmp_bench.sv
`timescale 1ns/1ps
module simd_sgt_cmp_bench;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [255:0] src_a = '0, src_b = '0, dst_old = '0;
   logic [1:0]   size_sel = 2'b00, mode_sel = 2'b00;
   logic         out_valid;
   logic [255:0] dst_out;

   int n_checks = 0;
   int n_fails  = 0;

   always #2 clk = ~clk;

   simd_sgt_cmp u_simd_sgt_cmp (
      .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
      .dst_old(dst_old), .size_sel(size_sel), .mode_sel(mode_sel),
      .out_valid(out_valid), .dst_out(dst_out));

   function automatic logic [255:0] rand_vec();
      logic [255:0] v;
      for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   // Reference model from R1-style rules, lanes per R2, upper half per mode
   function automatic logic [255:0] model(logic [255:0] a, logic [255:0] b,
                                          logic [255:0] old, logic [1:0] sz,
                                          logic [1:0] md);
      logic [255:0] r;
      int lw, nl;
      logic [63:0] lmask, sbit, xa, xb;
      lw = 8 << sz;
      nl = (md[1] ? 256 : 128) / lw;
      lmask = (lw == 64) ? {64{1'b1}} : ((64'd1 << lw) - 64'd1);
      sbit  = 64'd1 << (lw - 1);
      r = '0;
      for (int l = 0; l < nl; l++) begin
         xa = 64'((a >> (l*lw))) & lmask;
         xb = 64'((b >> (l*lw))) & lmask;
         if ((xa ^ sbit) > (xb ^ sbit))
            r = r | (256'(lmask) << (l*lw));
      end
      if (md == 2'b00) r[255:128] = old[255:128];
      return r;
   endfunction

   function automatic logic [255:0] fill(logic [1:0] sz, logic [63:0] val);
      logic [255:0] v;
      int lw;
      lw = 8 << sz;
      v = '0;
      for (int l = 0; l < 256/lw; l++)
         v = v | ((256'(val) & ((256'd1 << lw) - 256'd1)) << (l*lw));
      return v;
   endfunction

   task automatic check_vec(string tag, logic [255:0] act, logic [255:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_bit(string tag, logic act, logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic run_op(string tag, logic [255:0] a, logic [255:0] b,
                         logic [255:0] old, logic [1:0] sz, logic [1:0] md);
      @(negedge clk);
      src_a = a; src_b = b; dst_old = old; size_sel = sz; mode_sel = md;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check_bit({tag, " R7 out_valid"}, out_valid, 1'b1);
      check_vec(tag, dst_out, model(a, b, old, sz, md));
   endtask

   task automatic t_reset();
      check_bit("R7 reset out_valid", out_valid, 1'b0);
      check_vec("R7 reset data", dst_out, '0);
      // operation presented during reset is dropped
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b1; src_a = fill(2'b00, 64'h05);
      @(negedge clk);
      check_bit("R7 valid under reset", out_valid, 1'b0);
      rst = 1'b0; in_valid = 1'b0;
      @(negedge clk);
      check_bit("R7 idle after reset", out_valid, 1'b0);
   endtask

   task automatic t_random_all();
      for (int sz = 0; sz < 4; sz++)
         for (int md = 0; md < 4; md++)
            for (int k = 0; k < 6; k++)
               run_op("R1 R2 R5 R6 random", rand_vec(), rand_vec(), rand_vec(),
                      2'(sz), 2'(md));
   endtask

   task automatic t_corners();
      for (int sz = 0; sz < 4; sz++) begin
         logic [63:0] mn, mx;
         mn = 64'd1 << ((8 << sz) - 1);
         mx = mn - 64'd1;
         run_op("R1 min vs max", fill(2'(sz), mn), fill(2'(sz), mx), '0, 2'(sz), 2'b10);
         check_vec("R1 min never greater", dst_out, '0);
         run_op("R1 max vs min", fill(2'(sz), mx), fill(2'(sz), mn), '0, 2'(sz), 2'b10);
         check_vec("R1 max beats min", dst_out, {256{1'b1}});
         run_op("R1 equal", fill(2'(sz), mx), fill(2'(sz), mx), '0, 2'(sz), 2'b10);
         check_vec("R1 equal gives zero", dst_out, '0);
         run_op("R1 -1 vs 0", fill(2'(sz), {64{1'b1}}), '0, '0, 2'(sz), 2'b10);
      end
   endtask

   task automatic t_lane_order();
      for (int sz = 0; sz < 4; sz++) begin
         int lw;
         lw = 8 << sz;
         for (int l = 0; l < 256/lw; l += 3) begin
            logic [255:0] a, exp;
            a   = 256'd1 << (l*lw);
            exp = (lw == 256) ? '0 : ((256'd1 << lw) - 256'd1) << (l*lw);
            run_op("R2 R8 single lane", a, '0, '0, 2'(sz), 2'b11);
            check_vec("R2 R8 lane position", dst_out, exp);
         end
      end
   endtask

   task automatic t_modes();
      logic [255:0] a, b, old;
      a = fill(2'b00, 64'h10); b = fill(2'b00, 64'h01); old = rand_vec();
      run_op("R3 keep", a, b, old, 2'b00, 2'b00);
      check_vec("R3 upper kept", {128'd0, dst_out[255:128]}, {128'd0, old[255:128]});
      run_op("R4 clear", a, b, old, 2'b00, 2'b01);
      check_vec("R4 upper zero", {128'd0, dst_out[255:128]}, '0);
      run_op("R5 wide", a, b, old, 2'b00, 2'b10);
      check_vec("R5 all set", dst_out, {256{1'b1}});
      run_op("R6 reserved", a, b, old, 2'b00, 2'b11);
      check_vec("R6 same as wide", dst_out, {256{1'b1}});
   endtask

   task automatic t_hold();
      logic [255:0] snap;
      run_op("R9 setup", rand_vec(), rand_vec(), rand_vec(), 2'b01, 2'b10);
      snap = dst_out;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         src_a = rand_vec(); src_b = rand_vec(); dst_old = rand_vec();
         mode_sel = 2'(k); size_sel = 2'(k);
         @(negedge clk);
         check_bit("R9 R7 valid low when idle", out_valid, 1'b0);
         check_vec("R9 hold when idle", dst_out, snap);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_modes();
      t_corners();
      t_lane_order();
      t_random_all();
      t_hold();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule